// File: doc/BRIEF.md
# UART Automatic Baud Rate Detector

This block finds the bit rate of an asynchronous serial host instead of being configured with one. After a start request it watches the synchronized receive line for a falling edge and counts system clocks until the next rising edge. The host repeats the byte 0x00 during calibration, so the low interval covers the start bit and all eight data bits, which is nine bit times. The block divides that count by nine, rounded to the nearest integer, to get a bit-period divisor in clock cycles.

With the new divisor the block sends one 0x00 frame as an acknowledgement. It then switches its receiver on and expects the host to answer with 0x55. A correct answer sets the locked flag. A wrong byte, a bad stop bit, or a low interval too long for the counter sets the error flag. Both flags stay set until the next start request or reset. Frames use 8 data bits, LSB first, one stop bit and no parity.

Top module: `uart_autobaud`

## Requirements
- R1: After reset, txd is 1, locked is 0, error is 0 and divisor is 0, and low pulses on rxd have no effect until start is pulsed.
- R2: For an accepted low interval of L clock cycles on rxd, divisor becomes floor((L+4)/9), which is L/9 rounded to nearest.
- R3: A low interval shorter than MIN_LOW cycles is ignored: divisor keeps its value, no acknowledgement is sent, and the next valid low interval is measured.
- R4: A low interval of 2^CNT_W-1 cycles is accepted. A low interval longer than that sets error and leaves locked at 0.
- R5: After an accepted interval, txd sends exactly one frame at the derived rate: low for 9*divisor cycles (start bit plus data 0x00), then high. When no frame is being sent, txd is high.
- R6: After the acknowledgement, a frame carrying 0x55 (LSB first, start bit low, stop bit high) received at the derived rate sets locked to 1.
- R7: If the frame received after the acknowledgement holds a byte other than 0x55, or its stop bit is low, error is set and locked stays 0.
- R8: Locked and error hold their values through any activity on rxd until start is pulsed. Start clears both, keeps divisor, and begins a new measurement.
- R9: Timing begins only on a falling edge seen after start. A low level already present when start arrives is not timed, and an idle high interval of any length before the pulse is tolerated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | One-cycle pulse that begins (or restarts) calibration |
| rxd | input | 1 | Asynchronous serial receive line from the host, idle high |
| txd | output | 1 | Serial transmit line to the host, idle high |
| divisor | output | CNT_W-3 | Derived bit period in clock cycles |
| locked | output | 1 | Handshake completed with 0x55 |
| error | output | 1 | Counter overflow or bad confirmation frame |

## Verification
A wrong count or a wrong rounding shows on divisor within three cycles of the rising edge that ends the low interval. The sweep over every interval length from the glitch limit upward catches an off-by-one there. A fault in the transmitter's bit timing shows as a txd low width other than nine times the divisor during the acknowledgement. A fault in the receiver's sampling point or bit order shows within one frame as error instead of locked, or locked instead of error. Faults in state retention show when the bench keeps traffic on rxd after locked or error is set and checks that the flag does not change.

// File: rtl/autobaud_pkg.sv
// Shared types and constants of the automatic baud rate detector.
// Assumes frames of 1 start bit, 8 data bits and 1 stop bit.
package autobaud_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_MEASURE,
        ST_COMPUTE,
        ST_SEND_ACK,
        ST_WAIT_CONFIRM,
        ST_LOCKED,
        ST_ERROR
    } ab_state_e;

    localparam logic [7:0] ACK_BYTE     = 8'h00;
    localparam logic [7:0] CONFIRM_BYTE = 8'h55;

endpackage

// File: rtl/ab_sync.sv
// Multi-stage synchronizer for an asynchronous, idle-high serial line.
// Assumes STAGES >= 2. Resets to the idle level (1).
module ab_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    // Shift the raw line through the synchronizer chain.
    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '1;
        else        chain <= {chain[STAGES-2:0], d};
    end

    assign q = chain[STAGES-1];

endmodule

// File: rtl/ab_tx.sv
// Single-frame serial transmitter: 1 start bit, 8 data bits LSB first, 1 stop bit.
// Each bit lasts div cycles. Assumes div >= 1 and div stays stable during a frame.
// abort stops a frame at once and returns the line to idle high.
module ab_tx #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic             abort,
    input  logic [DIV_W-1:0] div,
    input  logic [7:0]       data,
    output logic             txd,
    output logic             done
);

    logic             busy;
    logic [9:0]       frame;
    logic [3:0]       nbit;
    logic [DIV_W-1:0] tick;
    logic             bit_end;

    assign bit_end = (tick == div - DIV_W'(1));

    // Load, time and shift the outgoing frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            frame <= '1;
            nbit  <= '0;
            tick  <= '0;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            if (abort) begin
                busy <= 1'b0;
            end else if (go) begin
                busy  <= 1'b1;
                frame <= {1'b1, data, 1'b0};
                nbit  <= '0;
                tick  <= '0;
            end else if (busy) begin
                if (bit_end) begin
                    tick  <= '0;
                    frame <= {1'b1, frame[9:1]};
                    if (nbit == 4'd9) begin
                        busy <= 1'b0;
                        done <= 1'b1;
                    end else begin
                        nbit <= nbit + 4'd1;
                    end
                end else begin
                    tick <= tick + DIV_W'(1);
                end
            end
        end
    end

    assign txd = busy ? frame[0] : 1'b1;

    // R5: the line level does not change in the middle of a bit.
    a_r5_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !abort && !bit_end) |=> $stable(txd));

endmodule

// File: rtl/ab_rx.sv
// Single-frame serial receiver sampling each bit at its midpoint.
// Assumes div >= 2. It runs only while en is high and restarts from idle when en drops.
// done pulses after the stop bit is sampled. ok is the stop-bit level.
module ab_rx #(
    parameter int DIV_W = 13
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             rx_s,
    input  logic [DIV_W-1:0] div,
    output logic             done,
    output logic             ok,
    output logic [7:0]       data
);

    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_BITS} rx_phase_e;

    rx_phase_e        phase;
    logic [3:0]       nbit;
    logic [DIV_W-1:0] tick;
    logic [DIV_W-1:0] half;

    assign half = div >> 1;

    // Detect the start bit, then sample the data and stop bits one period apart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= RX_IDLE;
            nbit  <= '0;
            tick  <= '0;
            done  <= 1'b0;
            ok    <= 1'b0;
            data  <= '0;
        end else if (!en) begin
            phase <= RX_IDLE;
            done  <= 1'b0;
        end else begin
            done <= 1'b0;
            case (phase)
                RX_IDLE: begin
                    if (!rx_s) begin
                        phase <= RX_START;
                        tick  <= DIV_W'(1);
                    end
                end
                RX_START: begin
                    if (tick == half) begin
                        if (!rx_s) begin
                            phase <= RX_BITS;
                            nbit  <= '0;
                            tick  <= '0;
                        end else begin
                            phase <= RX_IDLE;
                        end
                    end else begin
                        tick <= tick + DIV_W'(1);
                    end
                end
                default: begin
                    if (tick == div - DIV_W'(1)) begin
                        tick <= '0;
                        if (nbit == 4'd8) begin
                            done  <= 1'b1;
                            ok    <= rx_s;
                            phase <= RX_IDLE;
                        end else begin
                            data <= {rx_s, data[7:1]};
                            nbit <= nbit + 4'd1;
                        end
                    end else begin
                        tick <= tick + DIV_W'(1);
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/uart_autobaud.sv
// Automatic baud rate detector. It times the low interval of a 0x00 calibration
// byte (9 bit times), derives a rounded divisor, sends a 0x00 acknowledgement
// and locks when the host answers with 0x55.
// Assumes MIN_LOW >= 18 so that the divisor is at least 2, and CNT_W >= 7.
module uart_autobaud
    import autobaud_pkg::*;
#(
    parameter int CNT_W   = 16,
    parameter int MIN_LOW = 36,
    localparam int DIV_W  = CNT_W - 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic             rxd,
    output logic             txd,
    output logic [DIV_W-1:0] divisor,
    output logic             locked,
    output logic             error
);

    localparam logic [CNT_W-1:0] CNT_MAX   = '1;
    localparam logic [CNT_W-1:0] MIN_LOW_C = CNT_W'(MIN_LOW);

    ab_state_e        state;
    logic             rx_s;
    logic             rx_q;
    logic             fall;
    logic             in_low;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W:0]   cnt_rnd;
    logic [DIV_W-1:0] div_next;
    logic             tx_go;
    logic             tx_done;
    logic             rx_done;
    logic             rx_ok;
    logic [7:0]       rx_byte;

    ab_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst_n(rst_n), .d(rxd), .q(rx_s)
    );

    // Hold the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) rx_q <= 1'b1;
        else        rx_q <= rx_s;
    end

    assign fall = rx_q && !rx_s;

    // Round to nearest: add half the divide-by-nine step (4) before dividing.
    assign cnt_rnd  = {1'b0, cnt} + (CNT_W+1)'(4);
    assign div_next = DIV_W'(cnt_rnd / (CNT_W+1)'(9));

    // Calibration sequence: measure, compute, acknowledge, confirm.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            in_low  <= 1'b0;
            cnt     <= '0;
            divisor <= '0;
            tx_go   <= 1'b0;
        end else begin
            tx_go <= 1'b0;
            if (start) begin
                state  <= ST_MEASURE;
                in_low <= 1'b0;
                cnt    <= '0;
            end else begin
                case (state)
                    ST_MEASURE: begin
                        if (!in_low) begin
                            if (fall) begin
                                in_low <= 1'b1;
                                cnt    <= CNT_W'(1);
                            end
                        end else if (!rx_s) begin
                            if (cnt == CNT_MAX) state <= ST_ERROR;
                            else                cnt   <= cnt + CNT_W'(1);
                        end else begin
                            in_low <= 1'b0;
                            if (cnt >= MIN_LOW_C) state <= ST_COMPUTE;
                        end
                    end
                    ST_COMPUTE: begin
                        divisor <= div_next;
                        tx_go   <= 1'b1;
                        state   <= ST_SEND_ACK;
                    end
                    ST_SEND_ACK: begin
                        if (tx_done) state <= ST_WAIT_CONFIRM;
                    end
                    ST_WAIT_CONFIRM: begin
                        if (rx_done)
                            state <= (rx_ok && rx_byte == CONFIRM_BYTE) ? ST_LOCKED : ST_ERROR;
                    end
                    default: ;
                endcase
            end
        end
    end

    ab_tx #(.DIV_W(DIV_W)) i_tx (
        .clk(clk), .rst_n(rst_n), .go(tx_go), .abort(start),
        .div(divisor), .data(ACK_BYTE), .txd(txd), .done(tx_done)
    );

    ab_rx #(.DIV_W(DIV_W)) i_rx (
        .clk(clk), .rst_n(rst_n), .en(state == ST_WAIT_CONFIRM), .rx_s(rx_s),
        .div(divisor), .done(rx_done), .ok(rx_ok), .data(rx_byte)
    );

    assign locked = (state == ST_LOCKED);
    assign error  = (state == ST_ERROR);

    // R3: only intervals of at least MIN_LOW cycles reach the divide step.
    a_r3_min_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPUTE) |-> (cnt >= MIN_LOW_C));

    // R2: the stored divisor is the count over nine, rounded to nearest.
    a_r2_rounding: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_COMPUTE && !start) |=>
            ((int'(divisor) * 9 <= int'($past(cnt)) + 4) &&
             (int'(divisor) * 9 + 9 > int'($past(cnt)) + 4)));

    // R6: lock only follows a received 0x55 with a valid stop bit.
    a_r6_lock_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(locked) |-> $past(rx_done && rx_ok && rx_byte == CONFIRM_BYTE));

    // R8: the final flags hold until start.
    a_r8_flags_hold: assert property (@(posedge clk) disable iff (!rst_n)
        ((locked || error) && !start) |=> $stable({locked, error}));

    // R4 / R7: error comes only from overflow or from the confirmation frame.
    a_r4_error_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(error) |-> ($past(state) == ST_WAIT_CONFIRM || $past(cnt) == CNT_MAX));

endmodule

// File: tb/test_uart_autobaud.sv
// Bench for the automatic baud rate detector with a small counter width.
module test_uart_autobaud;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W      = 10;
    localparam int MIN_LOW    = 36;
    localparam int DIV_W      = CNT_W - 3;
    localparam int CNT_MAX    = (1 << CNT_W) - 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic             rxd = 1'b1;
    logic             txd;
    logic [DIV_W-1:0] divisor;
    logic             locked;
    logic             error;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    uart_autobaud #(.CNT_W(CNT_W), .MIN_LOW(MIN_LOW)) i_uart_autobaud (
        .clk(clk), .rst_n(rst_n), .start(start), .rxd(rxd),
        .txd(txd), .divisor(divisor), .locked(locked), .error(error)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Watchdog: a hung run counts as a failure and still prints the summary.
    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles == 190000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired: actual %0d cycles expected fewer", cycles);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input string req, input int actual, input int expected);
        checks = checks + 1;
        if (actual != expected) begin
            errors = errors + 1;
            $display("FAIL %s: actual %0d expected %0d", req, actual, expected);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic low_pulse(input int len);
        @(negedge clk); rxd = 1'b0;
        for (int i = 1; i < len; i++) @(negedge clk);
        @(negedge clk); rxd = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input int per, input logic stop);
        @(negedge clk); rxd = 1'b0;
        for (int i = 1; i < per; i++) @(negedge clk);
        for (int k = 0; k < 8; k++) begin
            @(negedge clk); rxd = b[k];
            for (int i = 1; i < per; i++) @(negedge clk);
        end
        @(negedge clk); rxd = stop;
        for (int i = 1; i < per; i++) @(negedge clk);
        @(negedge clk); rxd = 1'b1;
    endtask

    // Watch the acknowledgement frame and check its low width and stop level.
    task automatic watch_ack(input int d);
        int wait_n = 0;
        int low_n  = 0;
        int high_ok = 1;
        while (txd == 1'b1 && wait_n < 200) begin
            @(negedge clk); wait_n++;
        end
        while (txd == 1'b0 && low_n < 4000) begin
            @(negedge clk); low_n++;
        end
        check("R5 ack low width", low_n, 9 * d);
        for (int i = 0; i < d + 4; i++) begin
            if (txd != 1'b1) high_ok = 0;
            @(negedge clk);
        end
        check("R5 ack stop high", high_ok, 1);
    endtask

    task automatic handshake(input int d, input logic [7:0] b, input logic stop,
                             input int exp_lock);
        pulse_start;
        idle(10);
        low_pulse(9 * d);
        watch_ack(d);
        check("R2 divisor from 9*d", int'(divisor), d);
        idle(2);
        send_byte(b, d, stop);
        idle(2 * d + 10);
        if (exp_lock != 0) begin
            check("R6 locked after 0x55", int'(locked), 1);
            check("R6 no error after 0x55", int'(error), 0);
        end else begin
            check("R7 error after bad confirm", int'(error), 1);
            check("R7 not locked after bad confirm", int'(locked), 0);
        end
    endtask

    initial begin
        int prev;
        int tx_quiet;
        idle(4);
        rst_n = 1'b1;
        idle(2);
        // R1: reset state.
        check("R1 txd idle", int'(txd), 1);
        check("R1 locked low", int'(locked), 0);
        check("R1 error low", int'(error), 0);
        check("R1 divisor zero", int'(divisor), 0);
        // R1: no measurement before start.
        low_pulse(90);
        idle(20);
        check("R1 no measure before start", int'(divisor), 0);
        check("R1 no ack before start", int'(txd), 1);

        // R2: sweep every interval length from the glitch limit up.
        for (int len = MIN_LOW; len <= 300; len++) begin
            pulse_start;
            idle(3);
            low_pulse(len);
            idle(8);
            check("R2 rounding sweep", int'(divisor), (len + 4) / 9);
        end

        // R3: a short pulse is ignored, then a valid one is measured.
        pulse_start;
        idle(3);
        prev = int'(divisor);
        low_pulse(MIN_LOW - 1);
        tx_quiet = 1;
        for (int i = 0; i < 30; i++) begin
            if (txd != 1'b1) tx_quiet = 0;
            @(negedge clk);
        end
        check("R3 glitch keeps divisor", int'(divisor), prev);
        check("R3 glitch sends no ack", tx_quiet, 1);
        check("R3 glitch no error", int'(error), 0);
        low_pulse(45);
        idle(8);
        check("R3 valid pulse after glitch", int'(divisor), 5);

        // R9: a low already present at start is not timed; long idle is fine.
        pulse_start;
        idle(3);
        rxd = 1'b0;
        idle(5);
        prev = int'(divisor);
        pulse_start;
        idle(60);
        rxd = 1'b1;
        idle(20);
        check("R9 pre-existing low ignored", int'(divisor), prev);
        check("R9 pre-existing low no ack", int'(txd), 1);
        idle(3000);
        low_pulse(90);
        idle(8);
        check("R9 measured after long idle", int'(divisor), 10);

        // R4: the counter limit is accepted; one past it overflows.
        pulse_start;
        idle(3);
        low_pulse(CNT_MAX);
        idle(8);
        check("R4 max interval no error", int'(error), 0);
        check("R4 max interval divisor", int'(divisor), (CNT_MAX + 4) / 9);
        pulse_start;
        idle(3);
        low_pulse(CNT_MAX + 1);
        idle(8);
        check("R4 overflow error", int'(error), 1);
        check("R4 overflow not locked", int'(locked), 0);

        // R6 and R8: full handshakes at several rates, with flags held and cleared.
        for (int d = 4; d <= 20; d += 4) begin
            handshake(d, 8'h55, 1'b1, 1);
            send_byte(8'h00, d, 1'b1);
            idle(20);
            check("R8 locked holds through traffic", int'(locked), 1);
            check("R8 txd quiet while locked", int'(txd), 1);
            pulse_start;
            idle(2);
            check("R8 start clears locked", int'(locked), 0);
            check("R8 start keeps divisor", int'(divisor), d);
        end
        handshake(7, 8'h55, 1'b1, 1);

        // R7: wrong bytes and a low stop bit give error; R8 error holds.
        handshake(6, 8'h54, 1'b1, 0);
        handshake(6, 8'hD5, 1'b1, 0);
        handshake(6, 8'hAA, 1'b1, 0);
        handshake(9, 8'h55, 1'b0, 0);
        send_byte(8'h55, 9, 1'b1);
        idle(100);
        check("R8 error holds through traffic", int'(error), 1);
        check("R8 error not locked", int'(locked), 0);
        pulse_start;
        idle(2);
        check("R8 start clears error", int'(error), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule